// File: doc/BRIEF.md
# Guarded One-Time-Programmable Fuse Write Path

This block takes a single program request for a one-time-programmable fuse array and decides whether it may blow one bit. The request is an address word that names an array, a row and a column. Array 0 is kept as it is. Arrays 2 and 3 are folded onto internal planes 1 and 2, because array 1 does not exist. The request then passes a fixed-priority chain of guards: address validity, the global register lock, the program-enable configuration bit, the syndrome-store lock, the key-store lock and a fault report from the programming circuit. The first guard that fails decides the outcome.

A request that passes every guard sets exactly one bit in the internal fuse store, emits a set-bit command and clears the error status. A request that fails leaves the store untouched and sets the error status. In either case program-done pulses one cycle after the request. Two of the stored bits act as locks, so blowing them changes how later requests are judged. A combinational read port exposes any stored row.

Top module: `fuse_pgm_guard`

## Requirements
- R1: The address word is decoded as array = bits 12:11, row = bits 10:5 and column = bits 4:0. A granted request reports the in-plane bit index row*32+column on `set_bit`.
- R2: Array 0 maps to plane 0, array 2 to plane 1 and array 3 to plane 2. The plane is reported on `set_plane` and is used for the store update.
- R3: A request to array 1 is rejected with reason 1 (invalid address). No other guard is evaluated ahead of this one.
- R4: While `wr_lock` is high, every request to a valid array is rejected with reason 2.
- R5: While `pgm_en` is low and the request is not rejected by R3 or R4, it is rejected with reason 3.
- R6: Once plane 0, row 21, column 30 is set (the syndrome lock), requests to arrays 2 and 3 are rejected with reason 4. Array 0 requests are not affected by this lock.
- R7: Once plane 0, row 22, column 1 is set (the key lock), array 0 requests to rows 24 to 31 are rejected with reason 5. Other rows and other arrays are not affected by this lock.
- R8: A request that passes R3 to R7 while `blow_fault` is high is rejected with reason 6.
- R9: The guards rank in the order R3, R4, R5, R6, R7, R8. `err_reason` always reports the first failing guard, and reports 0 for a granted request.
- R10: A granted request sets exactly its addressed bit and pulses `set_valid`. It also drives `pgm_err` low and clears `err_status`.
- R11: Every request, granted or not, produces a one-cycle `pgm_done` pulse in the cycle after it. A rejected request also pulses `pgm_err`, sets `err_status` and changes no stored bit. No request means no `pgm_done`.
- R12: Stored bits only go from 0 to 1. Re-programming a bit that is already set is granted and changes nothing.
- R13: After reset, every stored bit is 0, both lock indicators are 0, and `pgm_done`, `pgm_err`, `err_status`, `set_valid` and `err_reason` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle program request strobe |
| req_addr | input | 13 | Array, row and column of the bit to program |
| wr_lock | input | 1 | Global register write lock is active |
| pgm_en | input | 1 | Program-enable configuration bit |
| blow_fault | input | 1 | Programming circuit reports a failed blow |
| rd_plane | input | 2 | Plane selected on the read port |
| rd_row | input | 6 | Row selected on the read port |
| rd_data | output | 32 | Stored row at rd_plane/rd_row (zero for plane 3) |
| pgm_done | output | 1 | Request finished (one-cycle pulse) |
| pgm_err | output | 1 | Request rejected (one-cycle pulse with pgm_done) |
| err_status | output | 1 | Outcome of the latest request, held |
| err_reason | output | 3 | Guard that rejected the latest request, 0 when granted |
| set_valid | output | 1 | Set-bit command issued (one-cycle pulse) |
| set_plane | output | 2 | Plane of the set-bit command |
| set_bit | output | 11 | In-plane bit index of the set-bit command |
| key_locked | output | 1 | Key-store lock fuse value |
| syn_locked | output | 1 | Syndrome-store lock fuse value |

## Verification
A fault inside this block shows up as a wrong `err_reason`, `set_bit` or `rd_data` value one cycle after the request that triggers it. Two kinds of fault take longer to surface. A corrupted stored bit appears at once on the read port, but it only changes a grant decision when it is one of the two lock fuses. A misplaced write stays invisible until the affected row is read back or a lock check depends on it. For that reason the bench keeps a model of all three planes and reads back every row at the end, not only the rows the requests targeted.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    // Outcome code of one program request; lower value = higher priority guard.
    typedef enum logic [2:0] {
        RSN_OK         = 3'd0,
        RSN_BAD_ARRAY  = 3'd1,
        RSN_REG_LOCK   = 3'd2,
        RSN_PGM_OFF    = 3'd3,
        RSN_SYN_LOCK   = 3'd4,
        RSN_KEY_LOCK   = 3'd5,
        RSN_BLOW_FAIL  = 3'd6
    } fpg_reason_e;

    // Array field width is fixed by the address layout.
    localparam int ARR_W   = 2;
    localparam int PLANE_W = 2;
    localparam int PLANES  = 3;

endpackage

// File: rtl/fpg_addr_decode.sv
module fpg_addr_decode
    import fpg_pkg::*;
#(
    parameter int ROW_W = 6,
    parameter int COL_W = 5
) (
    input  logic [ARR_W+ROW_W+COL_W-1:0] addr_i,
    output logic                         arr_ok_o,
    output logic                         hi_array_o,
    output logic [PLANE_W-1:0]           plane_o,
    output logic [ROW_W-1:0]             row_o,
    output logic [COL_W-1:0]             col_o,
    output logic [ROW_W+COL_W-1:0]       bit_idx_o
);
    localparam int ADDR_W = ARR_W + ROW_W + COL_W;
    localparam int BIT_W  = ROW_W + COL_W;

    logic [ARR_W-1:0] arr_w;

    assign arr_w     = addr_i[ADDR_W-1 -: ARR_W];
    assign row_o     = addr_i[COL_W +: ROW_W];
    assign col_o     = addr_i[COL_W-1:0];
    // Columns are a power of two, so row*COLS+col is the low address bits.
    assign bit_idx_o = addr_i[BIT_W-1:0];

    // Array 1 does not exist: arrays 2 and 3 fold down by one plane.
    always_comb begin
        arr_ok_o   = 1'b1;
        hi_array_o = 1'b0;
        plane_o    = '0;
        unique case (arr_w)
            2'd0: plane_o = PLANE_W'(0);
            2'd2: begin
                hi_array_o = 1'b1;
                plane_o    = PLANE_W'(1);
            end
            2'd3: begin
                hi_array_o = 1'b1;
                plane_o    = PLANE_W'(2);
            end
            default: arr_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpg_guard_chain.sv
module fpg_guard_chain
    import fpg_pkg::*;
#(
    parameter int ROW_W     = 6,
    parameter int KEY_FIRST = 24,
    parameter int KEY_LAST  = 31
) (
    input  logic             arr_ok_i,
    input  logic             hi_array_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             wr_lock_i,
    input  logic             pgm_en_i,
    input  logic             syn_lock_i,
    input  logic             key_lock_i,
    input  logic             blow_fault_i,
    output fpg_reason_e      reason_o
);
    logic in_key_rows;
    logic key_hit;
    logic syn_hit;

    assign in_key_rows = (row_i >= ROW_W'(KEY_FIRST)) && (row_i <= ROW_W'(KEY_LAST));
    assign key_hit     = key_lock_i && !hi_array_i && in_key_rows;
    assign syn_hit     = syn_lock_i && hi_array_i;

    // Fixed priority: the first failing guard decides the outcome.
    always_comb begin
        if (!arr_ok_i)          reason_o = RSN_BAD_ARRAY;
        else if (wr_lock_i)     reason_o = RSN_REG_LOCK;
        else if (!pgm_en_i)     reason_o = RSN_PGM_OFF;
        else if (syn_hit)       reason_o = RSN_SYN_LOCK;
        else if (key_hit)       reason_o = RSN_KEY_LOCK;
        else if (blow_fault_i)  reason_o = RSN_BLOW_FAIL;
        else                    reason_o = RSN_OK;
    end

endmodule

// File: rtl/fpg_fuse_store.sv
module fpg_fuse_store
    import fpg_pkg::*;
#(
    parameter int ROW_W   = 6,
    parameter int COL_W   = 5,
    parameter int SYN_ROW = 21,
    parameter int SYN_COL = 30,
    parameter int KEY_ROW = 22,
    parameter int KEY_COL = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en_i,
    input  logic [PLANE_W-1:0]      set_plane_i,
    input  logic [ROW_W-1:0]        set_row_i,
    input  logic [COL_W-1:0]        set_col_i,
    input  logic [PLANE_W-1:0]      rd_plane_i,
    input  logic [ROW_W-1:0]        rd_row_i,
    output logic [(1<<COL_W)-1:0]   rd_data_o,
    output logic                    syn_lock_o,
    output logic                    key_lock_o
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [COLS-1:0] mem_q [PLANES][ROWS];
    logic [COLS-1:0] mem_d [PLANES][ROWS];
    logic [COLS-1:0] col_mask;

    assign col_mask = COLS'(1) << set_col_i;

    // One word per row; a bit may only be OR-ed in (0 -> 1 only).
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            always_comb begin
                mem_d[p][r] = mem_q[p][r];
                if (set_en_i && set_plane_i == PLANE_W'(p) && set_row_i == ROW_W'(r)) begin
                    mem_d[p][r] = mem_q[p][r] | col_mask;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[p][r] <= '0;
                else        mem_q[p][r] <= mem_d[p][r];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int p = 0; p < PLANES; p++) begin
            if (rd_plane_i == PLANE_W'(p)) rd_data_o = mem_q[p][rd_row_i];
        end
    end

    assign syn_lock_o = mem_q[0][SYN_ROW][SYN_COL];
    assign key_lock_o = mem_q[0][KEY_ROW][KEY_COL];

endmodule

// File: rtl/fuse_pgm_guard.sv
module fuse_pgm_guard
    import fpg_pkg::*;
#(
    parameter int ROW_W     = 6,
    parameter int COL_W     = 5,
    parameter int SYN_ROW   = 21,
    parameter int SYN_COL   = 30,
    parameter int KEY_ROW   = 22,
    parameter int KEY_COL   = 1,
    parameter int KEY_FIRST = 24,
    parameter int KEY_LAST  = 31
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ARR_W+ROW_W+COL_W-1:0] req_addr,
    input  logic                        wr_lock,
    input  logic                        pgm_en,
    input  logic                        blow_fault,
    input  logic [PLANE_W-1:0]          rd_plane,
    input  logic [ROW_W-1:0]            rd_row,
    output logic [(1<<COL_W)-1:0]       rd_data,
    output logic                        pgm_done,
    output logic                        pgm_err,
    output logic                        err_status,
    output logic [2:0]                  err_reason,
    output logic                        set_valid,
    output logic [PLANE_W-1:0]          set_plane,
    output logic [ROW_W+COL_W-1:0]      set_bit,
    output logic                        key_locked,
    output logic                        syn_locked
);
    localparam int BIT_W = ROW_W + COL_W;

    typedef struct packed {
        logic               done;
        logic               err;
        logic               err_stat;
        fpg_reason_e        reason;
        logic               set_v;
        logic [PLANE_W-1:0] plane;
        logic [BIT_W-1:0]   bit_idx;
    } state_t;

    state_t st_d, st_q;

    logic               arr_ok_w, hi_array_w;
    logic [PLANE_W-1:0] plane_w;
    logic [ROW_W-1:0]   row_w;
    logic [COL_W-1:0]   col_w;
    logic [BIT_W-1:0]   bit_w;
    fpg_reason_e        reason_w;
    logic               grant_w;

    fpg_addr_decode #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
        .addr_i     (req_addr),
        .arr_ok_o   (arr_ok_w),
        .hi_array_o (hi_array_w),
        .plane_o    (plane_w),
        .row_o      (row_w),
        .col_o      (col_w),
        .bit_idx_o  (bit_w)
    );

    fpg_guard_chain #(.ROW_W(ROW_W), .KEY_FIRST(KEY_FIRST), .KEY_LAST(KEY_LAST)) u_chain (
        .arr_ok_i     (arr_ok_w),
        .hi_array_i   (hi_array_w),
        .row_i        (row_w),
        .wr_lock_i    (wr_lock),
        .pgm_en_i     (pgm_en),
        .syn_lock_i   (syn_locked),
        .key_lock_i   (key_locked),
        .blow_fault_i (blow_fault),
        .reason_o     (reason_w)
    );

    assign grant_w = req_valid && (reason_w == RSN_OK);

    fpg_fuse_store #(
        .ROW_W(ROW_W), .COL_W(COL_W),
        .SYN_ROW(SYN_ROW), .SYN_COL(SYN_COL),
        .KEY_ROW(KEY_ROW), .KEY_COL(KEY_COL)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en_i    (grant_w),
        .set_plane_i (plane_w),
        .set_row_i   (row_w),
        .set_col_i   (col_w),
        .rd_plane_i  (rd_plane),
        .rd_row_i    (rd_row),
        .rd_data_o   (rd_data),
        .syn_lock_o  (syn_locked),
        .key_lock_o  (key_locked)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.err   = 1'b0;
        st_d.set_v = 1'b0;
        if (req_valid) begin
            st_d.done     = 1'b1;
            st_d.reason   = reason_w;
            st_d.err      = (reason_w != RSN_OK);
            st_d.err_stat = (reason_w != RSN_OK);
            st_d.set_v    = grant_w;
            if (grant_w) begin
                st_d.plane   = plane_w;
                st_d.bit_idx = bit_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{done: 1'b0, err: 1'b0, err_stat: 1'b0, reason: RSN_OK,
                              set_v: 1'b0, plane: '0, bit_idx: '0};
        else        st_q <= st_d;
    end

    assign pgm_done   = st_q.done;
    assign pgm_err    = st_q.err;
    assign err_status = st_q.err_stat;
    assign err_reason = st_q.reason;
    assign set_valid  = st_q.set_v;
    assign set_plane  = st_q.plane;
    assign set_bit    = st_q.bit_idx;

endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
    parameter int ROW_W = 6,
    parameter int COL_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [2+ROW_W+COL_W-1:0] req_addr,
    input logic                   wr_lock,
    input logic                   pgm_en,
    input logic [1:0]             rd_plane,
    input logic [ROW_W-1:0]       rd_row,
    input logic [(1<<COL_W)-1:0]  rd_data,
    input logic                   pgm_done,
    input logic                   pgm_err,
    input logic                   err_status,
    input logic [2:0]             err_reason,
    input logic                   set_valid,
    input logic [1:0]             set_plane,
    input logic [ROW_W+COL_W-1:0] set_bit,
    input logic                   key_locked,
    input logic                   syn_locked
);
    localparam int AW = 2 + ROW_W + COL_W;

    assert_done_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pgm_done);

    assert_no_spurious_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pgm_done);

    assert_set_not_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_valid && pgm_err));

    assert_status_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_done |-> (err_status == pgm_err));

    assert_grant_reason_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (err_reason == 3'd0));

    assert_bad_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[AW-1 -: 2] == 2'd1) |=> (err_reason == 3'd1));

    assert_reg_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wr_lock && req_addr[AW-1 -: 2] != 2'd1) |=> (err_reason == 3'd2));

    assert_pgm_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_lock && !pgm_en && req_addr[AW-1 -: 2] != 2'd1) |=> (err_reason == 3'd3));

    assert_plane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (set_plane != 2'd3));

    assert_bit_visible_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_plane == rd_plane && set_bit[ROW_W+COL_W-1:COL_W] == rd_row)
        |-> rd_data[set_bit[COL_W-1:0]]);

    assert_key_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        key_locked |=> key_locked);

    assert_syn_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        syn_locked |=> syn_locked);

endmodule

bind fuse_pgm_guard fpg_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fpg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .wr_lock    (wr_lock),
    .pgm_en     (pgm_en),
    .rd_plane   (rd_plane),
    .rd_row     (rd_row),
    .rd_data    (rd_data),
    .pgm_done   (pgm_done),
    .pgm_err    (pgm_err),
    .err_status (err_status),
    .err_reason (err_reason),
    .set_valid  (set_valid),
    .set_plane  (set_plane),
    .set_bit    (set_bit),
    .key_locked (key_locked),
    .syn_locked (syn_locked)
);

// File: tb/fuse_pgm_guard_tb.sv
`timescale 1ns/1ps
module fuse_pgm_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [12:0] req_addr = '0;
    logic        wr_lock = 1'b0;
    logic        pgm_en = 1'b0;
    logic        blow_fault = 1'b0;
    logic [1:0]  rd_plane = '0;
    logic [5:0]  rd_row = '0;
    logic [31:0] rd_data;
    logic        pgm_done, pgm_err, err_status, set_valid, key_locked, syn_locked;
    logic [2:0]  err_reason;
    logic [1:0]  set_plane;
    logic [10:0] set_bit;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] mdl [0:2][0:63];

    always #2 clk = ~clk;

    fuse_pgm_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .wr_lock(wr_lock), .pgm_en(pgm_en), .blow_fault(blow_fault),
        .rd_plane(rd_plane), .rd_row(rd_row), .rd_data(rd_data),
        .pgm_done(pgm_done), .pgm_err(pgm_err), .err_status(err_status),
        .err_reason(err_reason), .set_valid(set_valid), .set_plane(set_plane),
        .set_bit(set_bit), .key_locked(key_locked), .syn_locked(syn_locked)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_reason(input int arr, input int row, input bit wl, input bit pe, input bit bf);
        if (arr == 1) return 1;
        if (wl) return 2;
        if (!pe) return 3;
        if (arr != 0 && mdl[0][21][30]) return 4;
        if (arr == 0 && mdl[0][22][1] && row >= 24 && row <= 31) return 5;
        if (bf) return 6;
        return 0;
    endfunction

    task automatic req(input int arr, input int row, input int col, input bit wl,
                       input bit pe, input bit bf, input string tag);
        int plane;
        int r;
        plane = (arr == 0) ? 0 : arr - 1;
        r = exp_reason(arr, row, wl, pe, bf);
        req_addr = {arr[1:0], row[5:0], col[4:0]};
        wr_lock = wl; pgm_en = pe; blow_fault = bf;
        req_valid = 1'b1;
        if (arr != 1) begin
            rd_plane = plane[1:0];
            rd_row = row[5:0];
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (r == 0) mdl[plane][row][col] = 1'b1;
        check(tag, "pgm_done", {31'd0, pgm_done}, 32'd1);
        check(tag, "pgm_err", {31'd0, pgm_err}, {31'd0, r != 0});
        check(tag, "err_reason", {29'd0, err_reason}, r);
        check(tag, "err_status", {31'd0, err_status}, {31'd0, r != 0});
        check(tag, "set_valid", {31'd0, set_valid}, {31'd0, r == 0});
        if (r == 0) check(tag, "set_cmd", {19'd0, set_plane, set_bit}, {19'd0, plane[1:0], 11'(row*32 + col)});
        if (arr != 1) check(tag, "row_readback", rd_data, mdl[plane][row]);
    endtask

    task automatic idle_check(input string tag);
        @(posedge clk); #1;
        check(tag, "idle_done", {31'd0, pgm_done}, 32'd0);
        check(tag, "idle_set", {31'd0, set_valid}, 32'd0);
    endtask

    task automatic sweep_readback(input string tag);
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 64; r++) begin
                rd_plane = p[1:0]; rd_row = r[5:0];
                #1;
                check(tag, "store_row", rd_data, (p < 3) ? mdl[p][r] : 32'd0);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 64; r++) mdl[p][r] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R13: reset state
        check("R13", "pgm_done", {31'd0, pgm_done}, 0);
        check("R13", "pgm_err", {31'd0, pgm_err}, 0);
        check("R13", "err_status", {31'd0, err_status}, 0);
        check("R13", "set_valid", {31'd0, set_valid}, 0);
        check("R13", "err_reason", {29'd0, err_reason}, 0);
        check("R13", "locks", {30'd0, key_locked, syn_locked}, 0);
        sweep_readback("R13");

        // R1 R2: every column of one row, every row with a walking column, per array
        for (int a = 0; a < 4; a++) begin
            if (a == 1) continue;
            for (int c = 0; c < 32; c++) req(a, 5, c, 0, 1, 0, "R1");
            for (int r = 0; r < 64; r++) req(a, r, (r * 7) % 32, 0, 1, 0, "R2");
        end
        idle_check("R11");

        // R3: array 1 rejected whatever the other inputs
        for (int k = 0; k < 8; k++) req(1, k * 9, k * 4, k[0], k[1], k[2], "R3");

        // R9 R4 R5 R8: all guard combinations on a key-store row, key lock still clear
        for (int a = 0; a < 4; a++)
            for (int k = 0; k < 8; k++)
                req(a, 24, 3 + k, k[0], k[1], k[2], "R9");

        // R8 + R11: failed blow leaves store unchanged
        req(0, 40, 9, 0, 1, 1, "R8");
        req(2, 41, 9, 0, 1, 1, "R11");
        idle_check("R11");

        // R7: blow the key lock, then sweep rows around the key store
        req(0, 22, 1, 0, 1, 0, "R7");
        check("R7", "key_locked", {31'd0, key_locked}, 1);
        for (int r = 20; r < 34; r++) req(0, r, 17, 0, 1, 0, "R7");
        req(2, 26, 17, 0, 1, 0, "R7");
        req(3, 30, 18, 0, 1, 0, "R7");
        req(0, 27, 2, 1, 1, 0, "R9");
        req(0, 27, 2, 0, 0, 0, "R9");

        // R6: blow the syndrome lock
        req(0, 21, 30, 0, 1, 0, "R6");
        check("R6", "syn_locked", {31'd0, syn_locked}, 1);
        for (int r = 0; r < 64; r += 5) begin
            req(2, r, 11, 0, 1, 0, "R6");
            req(3, r, 12, 0, 1, 0, "R6");
        end
        req(0, 10, 13, 0, 1, 0, "R6");
        req(2, 3, 4, 1, 1, 0, "R9");
        req(3, 3, 4, 0, 1, 1, "R9");
        req(0, 25, 4, 0, 1, 1, "R9");
        req(0, 12, 4, 0, 1, 1, "R8");

        // R10 R12: re-program existing bits, status clears after an error
        req(0, 5, 7, 0, 1, 0, "R12");
        req(2, 5, 31, 0, 1, 0, "R12");
        req(0, 22, 1, 0, 1, 0, "R12");
        req(1, 0, 0, 0, 1, 0, "R10");
        req(0, 63, 31, 0, 1, 0, "R10");
        idle_check("R11");

        sweep_readback("R12");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule